// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is the device side of a byte-wide parallel flash. It holds a small array, decodes each host write cycle's data byte as a command, and picks what a read cycle returns: array contents, identifier information or a status byte. Erase, lock-bit clearing and byte programming are sequences of two write cycles. The first write arms the operation. The second write either supplies the program data or confirms the operation with 0xD0.

An accepted operation occupies the device for a programmable number of clock cycles. During that time every read returns status with the ready bit low, and every write is dropped. Reads are combinational from `addr` and the current state. Writes take effect on the rising clock edge when `wr_en` is high.

Top module: `pflash_cmd_engine`

## Requirements
- R1: After reset the device is in array-read mode, every array byte reads 0xFF, and the status byte is 0x80.
- R2: Writing 0xFF when no operation is armed selects array-read mode. Later reads return the stored byte at `addr`.
- R3: Writing 0x90 selects identifier mode. A read at address 0 returns `MFG_CODE`. A read at address `1 << ADDR_SHIFT` returns `DEV_CODE`.
- R4: In identifier mode, a read at block offset 2 returns that block's lock bit in bit 0, where 1 means locked. A read at block offset 3 returns the master lock bit in bit 0. The identifier addresses of R3 take priority.
- R5: Writing 0x70 selects status mode. The status byte is {ready, 0, erase error, program error, 0, 0, lock/abort, 0}, with bit 7 first. Bits 6, 3, 2 and 0 always read 0.
- R6: Writing 0x50 clears status bits 5, 4 and 1 and leaves the read mode unchanged.
- R7: The sequence 0x20 followed by 0xD0 erases the block that contains the second cycle's address. Erase sets every byte of that block to 0xFF and leaves all other blocks as they were. Writing 0x20 selects status mode.
- R8: If the cycle after 0x20 or 0x60 carries any byte other than 0xD0, status bits 5 and 4 are set. In that case the array and the lock bits do not change, the device does not go busy, and it stays in status mode.
- R9: The sequence 0x40 followed by a data cycle programs the addressed byte to old AND data. Writing 0x40 selects status mode.
- R10: Programming or erasing a byte in a locked block sets status bit 1 and leaves the array unchanged. Once that block is unlocked, programming it works.
- R11: The sequence 0x60 followed by 0xD0 clears every block lock bit when the master lock is clear. When the master lock is set, the sequence sets status bit 1 and the lock bits are kept.
- R12: A confirmed erase, unlock or program keeps the device busy for exactly `BUSY_CYCLES` clock cycles. During those cycles every read returns status with bit 7 at 0, and every write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; write cycles are taken on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the current cycle |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Command or program data byte |
| rdata | output | 8 | Array, identifier or status byte, selected by mode |

## Verification
The assertions take for granted that `wr_en`, `addr` and `wdata` are stable around the rising edge, and that `rst_n` is asserted before the first edge that matters. They also assume the host never drives unknown values on the bus. The bench changes every input only on the falling clock edge and holds it there for the whole cycle, so each write is seen exactly once. It issues writes while the device is busy on purpose, because those writes must have no effect. It observes that through later array and status reads rather than through internal state.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

   typedef enum logic [1:0] {
      MD_ARRAY,
      MD_IDENT,
      MD_STATUS
   } rd_mode_e;

   typedef enum logic [1:0] {
      PD_NONE,
      PD_ERASE,
      PD_PROG,
      PD_UNLOCK
   } pend_e;

   localparam logic [7:0] CMD_RESET  = 8'hFF;
   localparam logic [7:0] CMD_IDENT  = 8'h90;
   localparam logic [7:0] CMD_STAT   = 8'h70;
   localparam logic [7:0] CMD_CLEAR  = 8'h50;
   localparam logic [7:0] CMD_ERASE  = 8'h20;
   localparam logic [7:0] CMD_PROG   = 8'h40;
   localparam logic [7:0] CMD_UNLOCK = 8'h60;
   localparam logic [7:0] CMD_CONF   = 8'hD0;

endpackage

// File: rtl/pflash_busy_timer.sv
module pflash_busy_timer #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("pflash_busy_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= CW'(CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   // R12
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   // R12
   busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (cnt == $past(cnt) - 1'b1));

   // R12
   no_overcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(CYCLES));

endmodule

// File: rtl/pflash_array.sv
module pflash_array #(
   parameter int AW = 8,
   parameter int BW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prog_en,
   input  logic          erase_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (prog_en) begin
         mem[wr_addr] <= mem[wr_addr] & wr_data;
      end else if (erase_en) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (AW'(i) >> BW == wr_addr >> BW) mem[i] <= 8'hFF;
         end
      end
   end

   assign rd_data = mem[rd_addr];

   // R9
   excl_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_en && erase_en));

   // R9
   prog_clears_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_en |=> ((mem[$past(wr_addr)] & ~$past(wr_data)) == 8'h00));

   // R7
   erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_en && !prog_en) |=> (mem[{$past(wr_addr[AW-1:BW]), {BW{1'b0}}}] == 8'hFF));

endmodule

// File: rtl/pflash_cmd_engine.sv
module pflash_cmd_engine
   import pflash_pkg::*;
#(
   parameter int          ADDR_W        = 8,
   parameter int          BLK_W         = 6,
   parameter int          BUSY_CYCLES   = 4,
   parameter logic [7:0]  MFG_CODE      = 8'h89,
   parameter logic [7:0]  DEV_CODE      = 8'hA7,
   parameter int          ADDR_SHIFT    = 0,
   parameter logic        MASTER_LOCK   = 1'b0,
   parameter logic [(1 << (ADDR_W - BLK_W)) - 1:0] BLK_LOCK_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);
   localparam int NBW     = ADDR_W - BLK_W;
   localparam int NUM_BLK = 1 << NBW;
   localparam logic [ADDR_W-1:0] DEV_OFS = ADDR_W'(1) << ADDR_SHIFT;

   if (ADDR_SHIFT < 0 || ADDR_SHIFT > 1) begin : g_bad_shift
      $error("pflash_cmd_engine: ADDR_SHIFT must be 0 or 1");
   end
   if (BLK_W < 2 || BLK_W >= ADDR_W) begin : g_bad_blk
      $error("pflash_cmd_engine: BLK_W must lie in [2, ADDR_W)");
   end
   if (ADDR_W > 12) begin : g_bad_aw
      $error("pflash_cmd_engine: ADDR_W above 12 makes the array too large");
   end

   rd_mode_e           mode;
   pend_e              pend;
   logic               err_erase, err_prog, err_lock;
   logic [NUM_BLK-1:0] blk_lock;
   logic               busy;
   logic               accept, confirm, tgt_locked, op_blocked;
   logic               prog_en, erase_en, unlk_go, op_start;
   logic [NBW-1:0]     blk_idx;
   logic [7:0]         arr_data, id_data, stat_byte;

   assign accept     = wr_en && !busy;
   assign confirm    = (wdata == CMD_CONF);
   assign blk_idx    = addr[ADDR_W-1:BLK_W];
   assign tgt_locked = blk_lock[blk_idx];
   assign op_blocked = (pend == PD_ERASE) ? tgt_locked : MASTER_LOCK;

   assign prog_en  = accept && (pend == PD_PROG) && !tgt_locked;
   assign erase_en = accept && (pend == PD_ERASE) && confirm && !tgt_locked;
   assign unlk_go  = accept && (pend == PD_UNLOCK) && confirm && !MASTER_LOCK;
   assign op_start = accept && ((pend == PD_PROG) ||
                     (((pend == PD_ERASE) || (pend == PD_UNLOCK)) && confirm));

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_lock
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       blk_lock[b] <= BLK_LOCK_INIT[b];
         else if (unlk_go) blk_lock[b] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= MD_ARRAY;
         pend      <= PD_NONE;
         err_erase <= 1'b0;
         err_prog  <= 1'b0;
         err_lock  <= 1'b0;
      end else if (accept) begin
         case (pend)
            PD_PROG: begin
               pend <= PD_NONE;
               mode <= MD_STATUS;
               if (tgt_locked) err_lock <= 1'b1;
            end
            PD_ERASE, PD_UNLOCK: begin
               pend <= PD_NONE;
               mode <= MD_STATUS;
               if (!confirm) begin
                  err_erase <= 1'b1;
                  err_prog  <= 1'b1;
               end else if (op_blocked) begin
                  err_lock  <= 1'b1;
               end
            end
            default: begin
               case (wdata)
                  CMD_RESET:  mode <= MD_ARRAY;
                  CMD_IDENT:  mode <= MD_IDENT;
                  CMD_STAT:   mode <= MD_STATUS;
                  CMD_CLEAR: begin
                     err_erase <= 1'b0;
                     err_prog  <= 1'b0;
                     err_lock  <= 1'b0;
                  end
                  CMD_ERASE:  begin pend <= PD_ERASE;  mode <= MD_STATUS; end
                  CMD_PROG:   begin pend <= PD_PROG;   mode <= MD_STATUS; end
                  CMD_UNLOCK: begin pend <= PD_UNLOCK; mode <= MD_STATUS; end
                  default: ;
               endcase
            end
         endcase
      end
   end

   pflash_busy_timer #(.CYCLES(BUSY_CYCLES)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (op_start),
      .busy  (busy)
   );

   pflash_array #(.AW(ADDR_W), .BW(BLK_W)) array_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog_en  (prog_en),
      .erase_en (erase_en),
      .wr_addr  (addr),
      .wr_data  (wdata),
      .rd_addr  (addr),
      .rd_data  (arr_data)
   );

   always_comb begin
      if (addr == '0)                         id_data = MFG_CODE;
      else if (addr == DEV_OFS)               id_data = DEV_CODE;
      else if (addr[BLK_W-1:0] == BLK_W'(2))  id_data = {7'b0, tgt_locked};
      else if (addr[BLK_W-1:0] == BLK_W'(3))  id_data = {7'b0, MASTER_LOCK};
      else                                    id_data = 8'h00;
   end

   assign stat_byte = {!busy, 1'b0, err_erase, err_prog, 2'b00, err_lock, 1'b0};

   always_comb begin
      if (busy) rdata = stat_byte;
      else begin
         case (mode)
            MD_ARRAY: rdata = arr_data;
            MD_IDENT: rdata = id_data;
            default:  rdata = stat_byte;
         endcase
      end
   end

   // R12
   busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!prog_en && !erase_en && !unlk_go));

   // R8
   bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (pend == PD_ERASE) && !confirm) |=>
         (err_erase && err_prog && (mode == MD_STATUS) && !busy));

   // R11
   master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (pend == PD_UNLOCK) && confirm && MASTER_LOCK) |=>
         ($stable(blk_lock) && err_lock));

   // R2
   reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (pend == PD_NONE) && (wdata == CMD_RESET)) |=> (mode == MD_ARRAY));

   // R6
   clear_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (pend == PD_NONE) && (wdata == CMD_CLEAR)) |=>
         (!err_erase && !err_prog && !err_lock));

endmodule

// File: tb/pflash_cmd_engine_tb_top.sv
module pflash_cmd_engine_tb_top;
   localparam int         AW    = 8;
   localparam int         BW    = 6;
   localparam int         BUSY  = 4;
   localparam logic [7:0] MFG   = 8'h89;
   localparam logic [7:0] DEV   = 8'hA7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   wire  [7:0] rdata;

   logic       lk_wr = 1'b0;
   logic [7:0] lk_addr = '0;
   logic [7:0] lk_wdata = '0;
   wire  [7:0] lk_rdata;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pflash_cmd_engine #(.ADDR_W(AW), .BLK_W(BW), .BUSY_CYCLES(BUSY),
      .MFG_CODE(MFG), .DEV_CODE(DEV), .ADDR_SHIFT(0), .MASTER_LOCK(1'b0),
      .BLK_LOCK_INIT(4'b0100)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata));

   pflash_cmd_engine #(.ADDR_W(AW), .BLK_W(BW), .BUSY_CYCLES(BUSY),
      .MFG_CODE(MFG), .DEV_CODE(DEV), .ADDR_SHIFT(0), .MASTER_LOCK(1'b1),
      .BLK_LOCK_INIT(4'b0010)) dut_lk_i (
      .clk(clk), .rst_n(rst_n), .wr_en(lk_wr), .addr(lk_addr),
      .wdata(lk_wdata), .rdata(lk_rdata));

   // Behavioural reference: 0 array, 1 ident, 2 status; pend 0 none, 1 erase, 2 prog, 3 unlock
   int  m_mem [256];
   bit  m_lock [4];
   int  m_mode, m_pend, m_busy;
   bit  e5, e4, e1;

   initial begin
      foreach (m_mem[i]) m_mem[i] = 255;
      m_lock = '{0, 0, 1, 0};
      m_mode = 0; m_pend = 0; m_busy = 0;
      e5 = 0; e4 = 0; e1 = 0;
   end

   function automatic logic [7:0] m_read(input logic [7:0] a);
      logic [7:0] st;
      st = {(m_busy == 0), 1'b0, e5, e4, 2'b00, e1, 1'b0};
      if (m_busy > 0 || m_mode == 2) return st;
      if (m_mode == 0) return 8'(m_mem[a]);
      if (a == 0) return MFG;
      if (a == 1) return DEV;
      if (a % 64 == 2) return {7'b0, m_lock[a / 64]};
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         if (m_busy > 0) m_busy--;
         else if (wr_en) begin
            int blk;
            blk = addr / 64;
            case (m_pend)
               2: begin
                  m_pend = 0; m_mode = 2; m_busy = BUSY;
                  if (m_lock[blk]) e1 = 1;
                  else m_mem[addr] = m_mem[addr] & int'(wdata);
               end
               1, 3: begin
                  m_mode = 2;
                  if (wdata != 8'hD0) begin e5 = 1; e4 = 1; end
                  else begin
                     m_busy = BUSY;
                     if (m_pend == 1) begin
                        if (m_lock[blk]) e1 = 1;
                        else for (int i = blk * 64; i < blk * 64 + 64; i++) m_mem[i] = 255;
                     end else begin
                        foreach (m_lock[i]) m_lock[i] = 0;
                     end
                  end
                  m_pend = 0;
               end
               default: begin
                  case (wdata)
                     8'hFF: m_mode = 0;
                     8'h90: m_mode = 1;
                     8'h70: m_mode = 2;
                     8'h50: begin e5 = 0; e4 = 0; e1 = 0; end
                     8'h20: begin m_pend = 1; m_mode = 2; end
                     8'h40: begin m_pend = 2; m_mode = 2; end
                     8'h60: begin m_pend = 3; m_mode = 2; end
                     default: ;
                  endcase
               end
            endcase
         end
      end
   end

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic cyc(input bit w, input logic [7:0] a, input logic [7:0] d, input string req);
      @(negedge clk);
      wr_en = w; addr = a; wdata = d;
      #1;
      check(req, rdata, m_read(a));
   endtask

   task automatic idle(input logic [7:0] a, input string req);
      for (int i = 0; i < BUSY; i++) cyc(1'b0, a, 8'h00, req);
   endtask

   task automatic lk_cyc(input bit w, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      lk_wr = w; lk_addr = a; lk_wdata = d;
      #1;
   endtask

   initial begin : watchdog
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      cyc(0, 8'h00, 8'h00, "R1");
      check("R1", rdata, 8'hFF);
      cyc(0, 8'h81, 8'h00, "R1");
      cyc(0, 8'hFF, 8'h00, "R1");
      // R5: status byte
      cyc(1, 8'h00, 8'h70, "R5");
      cyc(0, 8'h00, 8'h00, "R5");
      check("R5", rdata, 8'h80);
      // R3/R4: identifier reads
      cyc(1, 8'h00, 8'h90, "R3");
      cyc(0, 8'h00, 8'h00, "R3");
      check("R3", rdata, MFG);
      cyc(0, 8'h01, 8'h00, "R3");
      check("R3", rdata, DEV);
      cyc(0, 8'h02, 8'h00, "R4");
      cyc(0, 8'h03, 8'h00, "R4");
      cyc(0, 8'd130, 8'h00, "R4");
      check("R4", rdata, 8'h01);
      // R2: back to array
      cyc(1, 8'h00, 8'hFF, "R2");
      cyc(0, 8'h05, 8'h00, "R2");
      // R9 program, R12 writes during busy ignored
      cyc(1, 8'h05, 8'h40, "R9");
      cyc(1, 8'h05, 8'h5A, "R9");
      cyc(1, 8'h05, 8'hFF, "R12");
      check("R12", rdata, 8'h00);
      cyc(1, 8'h05, 8'h00, "R12");
      cyc(1, 8'h05, 8'h90, "R12");
      cyc(1, 8'h05, 8'h20, "R12");
      cyc(0, 8'h05, 8'h00, "R12");
      check("R12", rdata, 8'h80);
      cyc(1, 8'h00, 8'hFF, "R2");
      cyc(0, 8'h05, 8'h00, "R9");
      check("R9", rdata, 8'h5A);
      cyc(1, 8'h05, 8'h40, "R9");
      cyc(1, 8'h05, 8'h0F, "R9");
      idle(8'h05, "R12");
      cyc(1, 8'h00, 8'hFF, "R2");
      cyc(0, 8'h05, 8'h00, "R9");
      check("R9", rdata, 8'h0A);
      // program a byte in block 1, then erase block 0
      cyc(1, 8'd70, 8'h40, "R9");
      cyc(1, 8'd70, 8'h00, "R9");
      idle(8'd70, "R12");
      cyc(1, 8'd10, 8'h20, "R7");
      cyc(1, 8'd10, 8'hD0, "R7");
      idle(8'd10, "R12");
      cyc(1, 8'h00, 8'hFF, "R2");
      cyc(0, 8'h05, 8'h00, "R7");
      check("R7", rdata, 8'hFF);
      cyc(0, 8'd63, 8'h00, "R7");
      cyc(0, 8'd70, 8'h00, "R7");
      check("R7", rdata, 8'h00);
      // R8: bad confirm on erase and unlock
      cyc(1, 8'd70, 8'h20, "R8");
      cyc(1, 8'd70, 8'h33, "R8");
      cyc(0, 8'd70, 8'h00, "R8");
      check("R8", rdata, 8'hB0);
      cyc(1, 8'h00, 8'h50, "R6");
      cyc(0, 8'h00, 8'h00, "R6");
      check("R6", rdata, 8'h80);
      cyc(1, 8'h00, 8'h60, "R8");
      cyc(1, 8'h00, 8'h11, "R8");
      cyc(1, 8'h00, 8'h90, "R8");
      cyc(0, 8'd130, 8'h00, "R8");
      check("R8", rdata, 8'h01);
      cyc(1, 8'h00, 8'hFF, "R8");
      cyc(0, 8'd70, 8'h00, "R8");
      cyc(1, 8'h00, 8'h50, "R6");
      // R10: locked block
      cyc(1, 8'd130, 8'h40, "R10");
      cyc(1, 8'd130, 8'h00, "R10");
      idle(8'd130, "R12");
      cyc(0, 8'd130, 8'h00, "R10");
      check("R10", rdata, 8'h82);
      cyc(1, 8'h00, 8'hFF, "R10");
      cyc(0, 8'd130, 8'h00, "R10");
      check("R10", rdata, 8'hFF);
      cyc(1, 8'd140, 8'h20, "R10");
      cyc(1, 8'd140, 8'hD0, "R10");
      idle(8'd140, "R12");
      cyc(0, 8'd140, 8'h00, "R10");
      cyc(1, 8'h00, 8'h50, "R6");
      cyc(0, 8'h00, 8'h00, "R6");
      // R11: unlock with master clear
      cyc(1, 8'h00, 8'h60, "R11");
      cyc(1, 8'h00, 8'hD0, "R11");
      idle(8'h00, "R12");
      cyc(1, 8'h00, 8'h90, "R11");
      cyc(0, 8'd130, 8'h00, "R11");
      check("R11", rdata, 8'h00);
      cyc(1, 8'h00, 8'hFF, "R2");
      cyc(1, 8'd130, 8'h40, "R10");
      cyc(1, 8'd130, 8'h3C, "R10");
      idle(8'd130, "R12");
      cyc(1, 8'h00, 8'hFF, "R2");
      cyc(0, 8'd130, 8'h00, "R10");
      check("R10", rdata, 8'h3C);

      // R11: master lock set on the second instance
      lk_cyc(1, 8'h00, 8'h60);
      lk_cyc(1, 8'h00, 8'hD0);
      for (int i = 0; i < BUSY; i++) lk_cyc(0, 8'h00, 8'h00);
      lk_cyc(0, 8'h00, 8'h00);
      check("R11", lk_rdata, 8'h82);
      lk_cyc(1, 8'h00, 8'h90);
      lk_cyc(0, 8'd66, 8'h00);
      check("R11", lk_rdata, 8'h01);
      lk_cyc(0, 8'h03, 8'h00);
      check("R4", lk_rdata, 8'h01);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule